// File: doc/BRIEF.md
# Affine Binary-Curve Point Adder

This block adds two points of a non-supersingular elliptic curve y² + xy = x³ + a2·x² + a6 over GF(2^m). Points are in affine coordinates, and each point carries a flag that marks the point at infinity. The block is a sequencer with a small datapath. It computes the field sums itself with XOR. The one inversion and the three products of a general addition go to a field inverter and a field multiplier outside the block. Each unit is driven through a start pulse and answers with a done pulse. The block uses the single multiplier for all three products, one after another.

A caller loads both points and the curve constant a2 with a one-cycle `start` pulse while the block is idle. The block first sorts the operands into cases. If either operand is infinity, if the operands are negatives of each other, or if the operands share an x coordinate, the block answers at once and calls neither unit. Only a true general addition runs the chain: invert the x difference, multiply for the slope λ, square λ, form xR, multiply λ·(xP + xR), then form yR. An equal pair of operands needs point doubling, which this block does not do, so it is reported on an error flag. The result, its infinity flag and the error flag stay on the outputs until the next `done` pulse.

The parameter `FW` sets the field width m. `SETTLE_REG` adds one register stage after the case classifier, which costs one cycle per operation.

Top module: `ecpa_point_add`

## Requirements
- R1: After reset `done`, `r_err`, `r_inf`, `r_x`, `r_y`, `mul_start` and `inv_start` are all 0.
- R2: For operands where neither is infinity and xP ≠ xQ, the block gives one `done` pulse with r_inf = 0, r_err = 0, λ = (yP⊕yQ)·(xP⊕xQ)⁻¹, r_x = λ² ⊕ λ ⊕ xP ⊕ xQ ⊕ a2 and r_y = λ·(xP ⊕ r_x) ⊕ r_x ⊕ yP.
- R3: A general addition makes exactly one inverter call, with `inv_op` = xP⊕xQ, followed by exactly three multiplier calls. Their (`mul_a`, `mul_b`) pairs, in order, are (yP⊕yQ, inverse), (λ, λ) and (λ, xP⊕xR). The two units are never started in the same cycle.
- R4: If P is flagged infinity, the result is Q: r_inf equals Q's flag, the coordinates are Q's when Q is finite and zero otherwise, r_err = 0, and no unit is called.
- R5: If only Q is flagged infinity, the result is P with r_inf = 0 and r_err = 0, and no unit is called.
- R6: If xQ = xP and yQ = yP ⊕ xP (Q = −P, which includes P = Q when xP = 0), the result is infinity. An infinity result always has r_x = r_y = 0. No unit is called.
- R7: If Q = P with xP ≠ 0, `r_err` = 1, r_inf = 0, r_x = r_y = 0, and no unit is called. The error flag is never raised together with `r_inf`.
- R8: If xQ = xP but yQ matches neither yP nor yP ⊕ xP, the result is infinity and no unit is called.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. Operand inputs are sampled only by an accepted start.
- R10: `done` is a one-cycle pulse, and the result outputs hold their values until the next `done`.
- R11: `mul_start` and `inv_start` are one-cycle pulses. The block holds `mul_a`, `mul_b` and `inv_op` stable while it waits for the unit's done pulse, and it accepts any unit latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| p_x | input | FW | x coordinate of P |
| p_y | input | FW | y coordinate of P |
| p_inf | input | 1 | P is the point at infinity |
| q_x | input | FW | x coordinate of Q |
| q_y | input | FW | y coordinate of Q |
| q_inf | input | 1 | Q is the point at infinity |
| curve_a2 | input | FW | Curve constant a2 |
| r_x | output | FW | x coordinate of the result |
| r_y | output | FW | y coordinate of the result |
| r_inf | output | 1 | Result is the point at infinity |
| r_err | output | 1 | Operands were equal and need doubling |
| done | output | 1 | One-cycle pulse when the result is updated |
| mul_start | output | 1 | Multiplier request pulse |
| mul_a | output | FW | Multiplier first operand |
| mul_b | output | FW | Multiplier second operand |
| mul_done | input | 1 | Multiplier answer pulse |
| mul_res | input | FW | Multiplier product, valid with mul_done |
| inv_start | output | 1 | Inverter request pulse |
| inv_op | output | FW | Inverter operand |
| inv_done | input | 1 | Inverter answer pulse |
| inv_res | input | FW | Inverse, valid with inv_done |

## Verification
Two situations are hard to reach from the ports. The first is a second `start` that lands in the middle of a general addition, while the block waits on an external unit. The bench reaches it by holding the multiplier model's latency long and pulsing `start` with different operands during that wait. It then checks that exactly one result appears and that it belongs to the first operands. The second is the overlap between the negation case and the doubling case at xP = 0. The bench builds operands with that exact relation and checks that the block reports infinity, not an error.

// File: rtl/ecpa_pkg.sv
package ecpa_pkg;

   // operand classification produced before any field unit is used
   typedef enum logic [2:0] {
      PK_GEN  = 3'd0,   // distinct x: full chord addition
      PK_RETP = 3'd1,   // Q is infinity: result is P
      PK_RETQ = 3'd2,   // P is infinity: result is Q
      PK_INF  = 3'd3,   // same x, not doubling: result is infinity
      PK_ERR  = 3'd4    // equal points: doubling required
   } pa_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_DECIDE = 3'd2,
      ST_INV    = 3'd3,
      ST_LAM    = 3'd4,
      ST_SQR    = 3'd5,
      ST_YMUL   = 3'd6
   } pa_state_e;

endpackage

// File: rtl/ecpa_classify.sv
module ecpa_classify
   import ecpa_pkg::*;
#(
   parameter int FW      = 7,
   parameter int REG_OUT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] px,
   input  logic [FW-1:0] py,
   input  logic          pinf,
   input  logic [FW-1:0] qx,
   input  logic [FW-1:0] qy,
   input  logic          qinf,
   output pa_kind_e      kind
);

   pa_kind_e kind_c;

   // priority: infinity operands, then distinct x, then negation, then equality
   always_comb begin
      if (pinf)
         kind_c = PK_RETQ;
      else if (qinf)
         kind_c = PK_RETP;
      else if (px != qx)
         kind_c = PK_GEN;
      else if (qy == (py ^ px))
         kind_c = PK_INF;
      else if (qy == py)
         kind_c = PK_ERR;
      else
         kind_c = PK_INF;
   end

   generate
      if (REG_OUT != 0) begin : g_reg
         pa_kind_e kind_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               kind_q <= PK_GEN;
            else
               kind_q <= kind_c;
         end
         assign kind = kind_q;
      end else begin : g_comb
         assign kind = kind_c;
      end
   endgenerate

endmodule

// File: rtl/ecpa_ctrl.sv
module ecpa_ctrl
   import ecpa_pkg::*;
#(
   parameter int SETTLE = 0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  pa_kind_e  kind,
   input  logic      inv_done,
   input  logic      mul_done,
   output pa_state_e state,
   output logic      cap_en,
   output logic      ld_inv,
   output logic      ld_lam,
   output logic      ld_xr,
   output logic      fin,
   output logic      inv_start,
   output logic      mul_start
);

   pa_state_e st_q, st_d;
   logic      go_inv, go_mul;

   always_comb begin
      st_d   = st_q;
      cap_en = 1'b0;
      ld_inv = 1'b0;
      ld_lam = 1'b0;
      ld_xr  = 1'b0;
      fin    = 1'b0;
      go_inv = 1'b0;
      go_mul = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               cap_en = 1'b1;
               st_d   = (SETTLE != 0) ? ST_SETTLE : ST_DECIDE;
            end
         end
         ST_SETTLE: st_d = ST_DECIDE;
         ST_DECIDE: begin
            if (kind == PK_GEN) begin
               go_inv = 1'b1;
               st_d   = ST_INV;
            end else begin
               fin  = 1'b1;
               st_d = ST_IDLE;
            end
         end
         ST_INV: begin
            if (inv_done) begin
               ld_inv = 1'b1;
               go_mul = 1'b1;
               st_d   = ST_LAM;
            end
         end
         ST_LAM: begin
            if (mul_done) begin
               ld_lam = 1'b1;
               go_mul = 1'b1;
               st_d   = ST_SQR;
            end
         end
         ST_SQR: begin
            if (mul_done) begin
               ld_xr  = 1'b1;
               go_mul = 1'b1;
               st_d   = ST_YMUL;
            end
         end
         ST_YMUL: begin
            if (mul_done) begin
               fin  = 1'b1;
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         inv_start <= 1'b0;
         mul_start <= 1'b0;
      end else begin
         st_q      <= st_d;
         inv_start <= go_inv;
         mul_start <= go_mul;
      end
   end

   assign state = st_q;

   AST_MUL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |=> !mul_start); // R11
   AST_INV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_start |=> !inv_start); // R11
   AST_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      !(inv_start && mul_start)); // R3
   AST_MUL_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_start && state == ST_LAM) |-> $past(inv_done)); // R3

endmodule

// File: rtl/ecpa_dpath.sv
module ecpa_dpath
   import ecpa_pkg::*;
#(
   parameter int FW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [FW-1:0] p_x,
   input  logic [FW-1:0] p_y,
   input  logic          p_inf,
   input  logic [FW-1:0] q_x,
   input  logic [FW-1:0] q_y,
   input  logic          q_inf,
   input  logic [FW-1:0] curve_a2,
   input  pa_state_e     state,
   input  pa_kind_e      kind,
   input  logic          ld_inv,
   input  logic          ld_lam,
   input  logic          ld_xr,
   input  logic          fin,
   input  logic [FW-1:0] inv_res,
   input  logic [FW-1:0] mul_res,
   output logic [FW-1:0] cp_x,
   output logic [FW-1:0] cp_y,
   output logic          cp_inf,
   output logic [FW-1:0] cq_x,
   output logic [FW-1:0] cq_y,
   output logic          cq_inf,
   output logic [FW-1:0] inv_op,
   output logic [FW-1:0] mul_a,
   output logic [FW-1:0] mul_b,
   output logic [FW-1:0] r_x,
   output logic [FW-1:0] r_y,
   output logic          r_inf,
   output logic          r_err,
   output logic          done
);

   localparam logic [FW-1:0] ZERO = '0;

   logic [FW-1:0] ca2, tinv, lam, xr;
   logic [FW-1:0] dx, dy;
   logic          mul_wait;

   // field additions are plain XOR
   assign dx     = cp_x ^ cq_x;
   assign dy     = cp_y ^ cq_y;
   assign inv_op = dx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cp_x <= ZERO; cp_y <= ZERO; cp_inf <= 1'b0;
         cq_x <= ZERO; cq_y <= ZERO; cq_inf <= 1'b0;
         ca2  <= ZERO;
      end else if (cap_en) begin
         cp_x <= p_x; cp_y <= p_y; cp_inf <= p_inf;
         cq_x <= q_x; cq_y <= q_y; cq_inf <= q_inf;
         ca2  <= curve_a2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tinv <= ZERO;
         lam  <= ZERO;
         xr   <= ZERO;
      end else begin
         if (ld_inv) tinv <= inv_res;
         if (ld_lam) lam  <= mul_res;
         if (ld_xr)  xr   <= mul_res ^ lam ^ dx ^ ca2;
      end
   end

   // operand steering for the shared multiplier
   always_comb begin
      mul_a = ZERO;
      mul_b = ZERO;
      case (state)
         ST_LAM:  begin mul_a = dy;  mul_b = tinv;      end
         ST_SQR:  begin mul_a = lam; mul_b = lam;       end
         ST_YMUL: begin mul_a = lam; mul_b = cp_x ^ xr; end
         default: ;
      endcase
   end

   assign mul_wait = (state == ST_LAM) || (state == ST_SQR) || (state == ST_YMUL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_x   <= ZERO;
         r_y   <= ZERO;
         r_inf <= 1'b0;
         r_err <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= fin;
         if (fin) begin
            case (kind)
               PK_GEN: begin
                  r_x <= xr; r_y <= mul_res ^ xr ^ cp_y;
                  r_inf <= 1'b0; r_err <= 1'b0;
               end
               PK_RETP: begin
                  r_x <= cp_inf ? ZERO : cp_x; r_y <= cp_inf ? ZERO : cp_y;
                  r_inf <= cp_inf; r_err <= 1'b0;
               end
               PK_RETQ: begin
                  r_x <= cq_inf ? ZERO : cq_x; r_y <= cq_inf ? ZERO : cq_y;
                  r_inf <= cq_inf; r_err <= 1'b0;
               end
               PK_ERR: begin
                  r_x <= ZERO; r_y <= ZERO; r_inf <= 1'b0; r_err <= 1'b1;
               end
               default: begin
                  r_x <= ZERO; r_y <= ZERO; r_inf <= 1'b1; r_err <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(r_x) && $stable(r_y) && $stable(r_inf))); // R10
   AST_INF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      r_inf |-> (r_x == ZERO && r_y == ZERO)); // R6
   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      r_err |-> !r_inf); // R7
   AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_wait && $stable(state)) |-> ($stable(mul_a) && $stable(mul_b))); // R11
   AST_INV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INV) |-> $stable(inv_op)); // R11

endmodule

// File: rtl/ecpa_point_add.sv
module ecpa_point_add
   import ecpa_pkg::*;
#(
   parameter int FW         = 7,
   parameter int SETTLE_REG = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] p_x,
   input  logic [FW-1:0] p_y,
   input  logic          p_inf,
   input  logic [FW-1:0] q_x,
   input  logic [FW-1:0] q_y,
   input  logic          q_inf,
   input  logic [FW-1:0] curve_a2,
   output logic [FW-1:0] r_x,
   output logic [FW-1:0] r_y,
   output logic          r_inf,
   output logic          r_err,
   output logic          done,
   output logic          mul_start,
   output logic [FW-1:0] mul_a,
   output logic [FW-1:0] mul_b,
   input  logic          mul_done,
   input  logic [FW-1:0] mul_res,
   output logic          inv_start,
   output logic [FW-1:0] inv_op,
   input  logic          inv_done,
   input  logic [FW-1:0] inv_res
);

   generate
      if (FW < 2 || FW > 64) begin : g_bad_fw
         $error("ecpa_point_add: FW must lie in 2..64");
      end
      if (SETTLE_REG != 0 && SETTLE_REG != 1) begin : g_bad_settle
         $error("ecpa_point_add: SETTLE_REG must be 0 or 1");
      end
   endgenerate

   pa_kind_e      kind;
   pa_state_e     state;
   logic          cap_en, ld_inv, ld_lam, ld_xr, fin;
   logic [FW-1:0] cp_x, cp_y, cq_x, cq_y;
   logic          cp_inf, cq_inf;

   ecpa_ctrl #(.SETTLE(SETTLE_REG)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .kind      (kind),
      .inv_done  (inv_done),
      .mul_done  (mul_done),
      .state     (state),
      .cap_en    (cap_en),
      .ld_inv    (ld_inv),
      .ld_lam    (ld_lam),
      .ld_xr     (ld_xr),
      .fin       (fin),
      .inv_start (inv_start),
      .mul_start (mul_start)
   );

   ecpa_classify #(.FW(FW), .REG_OUT(SETTLE_REG)) u_class (
      .clk   (clk),
      .rst_n (rst_n),
      .px    (cp_x),
      .py    (cp_y),
      .pinf  (cp_inf),
      .qx    (cq_x),
      .qy    (cq_y),
      .qinf  (cq_inf),
      .kind  (kind)
   );

   ecpa_dpath #(.FW(FW)) u_dpath (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .p_x      (p_x),
      .p_y      (p_y),
      .p_inf    (p_inf),
      .q_x      (q_x),
      .q_y      (q_y),
      .q_inf    (q_inf),
      .curve_a2 (curve_a2),
      .state    (state),
      .kind     (kind),
      .ld_inv   (ld_inv),
      .ld_lam   (ld_lam),
      .ld_xr    (ld_xr),
      .fin      (fin),
      .inv_res  (inv_res),
      .mul_res  (mul_res),
      .cp_x     (cp_x),
      .cp_y     (cp_y),
      .cp_inf   (cp_inf),
      .cq_x     (cq_x),
      .cq_y     (cq_y),
      .cq_inf   (cq_inf),
      .inv_op   (inv_op),
      .mul_a    (mul_a),
      .mul_b    (mul_b),
      .r_x      (r_x),
      .r_y      (r_y),
      .r_inf    (r_inf),
      .r_err    (r_err),
      .done     (done)
   );

   AST_INV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      inv_start |-> (inv_op != '0)); // R3

endmodule

// File: tb/test_ecpa_point_add.sv
`timescale 1ns/1ps
module test_ecpa_point_add;

   localparam int FW = 7;
   localparam logic [FW-1:0] RED = 7'h03;   // x^7 + x + 1

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FW-1:0] p_x = '0, p_y = '0, q_x = '0, q_y = '0, a2 = '0;
   logic          p_inf = 1'b0, q_inf = 1'b0;
   logic [FW-1:0] r_x, r_y, mul_a, mul_b, inv_op;
   logic          r_inf, r_err, done, mul_start, inv_start;
   logic          mul_done = 1'b0, inv_done = 1'b0;
   logic [FW-1:0] mul_res = '0, inv_res = '0;

   int n_chk = 0, n_bad = 0;
   int mul_lat = 1, inv_lat = 1;
   int mul_calls = 0, inv_calls = 0;
   logic [FW-1:0] mlog_a [4];
   logic [FW-1:0] mlog_b [4];
   logic [FW-1:0] ilog;
   int mcnt = 0, icnt = 0;
   logic [FW-1:0] ma, mb, iop;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ecpa_point_add #(.FW(FW)) i_ecpa_point_add (
      .clk(clk), .rst_n(rst_n), .start(start),
      .p_x(p_x), .p_y(p_y), .p_inf(p_inf),
      .q_x(q_x), .q_y(q_y), .q_inf(q_inf), .curve_a2(a2),
      .r_x(r_x), .r_y(r_y), .r_inf(r_inf), .r_err(r_err), .done(done),
      .mul_start(mul_start), .mul_a(mul_a), .mul_b(mul_b),
      .mul_done(mul_done), .mul_res(mul_res),
      .inv_start(inv_start), .inv_op(inv_op),
      .inv_done(inv_done), .inv_res(inv_res)
   );

   function automatic logic [FW-1:0] gmul(input logic [FW-1:0] a, input logic [FW-1:0] b);
      logic [FW-1:0] r = '0;
      for (int i = FW - 1; i >= 0; i--) begin
         r = r[FW-1] ? ((r << 1) ^ RED) : (r << 1);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   function automatic logic [FW-1:0] ginv(input logic [FW-1:0] a);
      logic [FW-1:0] r = '0;
      for (int v = 1; v < (1 << FW); v++)
         if (gmul(a, v[FW-1:0]) == 1) r = v[FW-1:0];
      return r;
   endfunction

   // behavioural field units with adjustable latency
   always @(posedge clk) begin
      mul_done <= 1'b0;
      if (mul_start) begin
         ma <= mul_a; mb <= mul_b; mcnt <= mul_lat;
         mlog_a[mul_calls % 4] <= mul_a;
         mlog_b[mul_calls % 4] <= mul_b;
         mul_calls <= mul_calls + 1;
      end else if (mcnt != 0) begin
         mcnt <= mcnt - 1;
         if (mcnt == 1) begin mul_done <= 1'b1; mul_res <= gmul(ma, mb); end
      end
   end

   always @(posedge clk) begin
      inv_done <= 1'b0;
      if (inv_start) begin
         iop <= inv_op; icnt <= inv_lat; ilog <= inv_op;
         inv_calls <= inv_calls + 1;
      end else if (icnt != 0) begin
         icnt <= icnt - 1;
         if (icnt == 1) begin inv_done <= 1'b1; inv_res <= ginv(iop); end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [FW-1:0] g_x, g_y;
   logic          g_inf, g_err;
   int            base_m, base_i;

   // drive one operation and wait for its done pulse; also checks R10
   task automatic run_op(input logic [FW-1:0] px, py, input logic pi,
                         input logic [FW-1:0] qx, qy, input logic qi,
                         input logic [FW-1:0] ca2);
      int n = 0;
      @(negedge clk);
      base_m = mul_calls; base_i = inv_calls;
      p_x = px; p_y = py; p_inf = pi; q_x = qx; q_y = qy; q_inf = qi; a2 = ca2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      p_x = ~px; q_y = ~qy;   // inputs after the accepted start must not matter
      while (!done && n < 400) begin @(negedge clk); n++; end
      chk(done, "R10", "done seen", {31'd0, done}, 32'd1);
      g_x = r_x; g_y = r_y; g_inf = r_inf; g_err = r_err;
      @(negedge clk);
      chk(!done, "R10", "done single cycle", {31'd0, done}, 32'd0);
      repeat (3) @(negedge clk);
      chk(r_x == g_x && r_y == g_y && r_inf == g_inf && r_err == g_err, "R10",
          "result held", {r_x, r_y}, {g_x, g_y});
   endtask

   task automatic t_general(input logic [FW-1:0] px, py, qx, qy, ca2,
                            input int ml, input int il);
      logic [FW-1:0] dx, dy, t, lam, xr, yr;
      mul_lat = ml; inv_lat = il;
      dx = px ^ qx; dy = py ^ qy; t = ginv(dx);
      lam = gmul(dy, t);
      xr  = gmul(lam, lam) ^ lam ^ dx ^ ca2;
      yr  = gmul(lam, px ^ xr) ^ xr ^ py;
      run_op(px, py, 1'b0, qx, qy, 1'b0, ca2);
      chk(g_x == xr, "R2", "r_x", g_x, xr);
      chk(g_y == yr, "R2", "r_y", g_y, yr);
      chk(!g_inf && !g_err, "R2", "flags", {g_inf, g_err}, 0);
      chk(inv_calls - base_i == 1, "R3", "inverter calls", inv_calls - base_i, 1);
      chk(mul_calls - base_m == 3, "R3", "multiplier calls", mul_calls - base_m, 3);
      chk(ilog == dx, "R3", "inv operand", ilog, dx);
      chk(mlog_a[base_m % 4] == dy && mlog_b[base_m % 4] == t, "R3", "mul 1",
          {mlog_a[base_m % 4], mlog_b[base_m % 4]}, {dy, t});
      chk(mlog_a[(base_m + 1) % 4] == lam && mlog_b[(base_m + 1) % 4] == lam, "R3", "mul 2",
          {mlog_a[(base_m + 1) % 4], mlog_b[(base_m + 1) % 4]}, {lam, lam});
      chk(mlog_a[(base_m + 2) % 4] == lam && mlog_b[(base_m + 2) % 4] == (px ^ xr), "R11",
          "mul 3 operands under latency", {mlog_a[(base_m + 2) % 4], mlog_b[(base_m + 2) % 4]},
          {lam, px ^ xr});
   endtask

   task automatic no_units(input string req);
      chk(mul_calls == base_m && inv_calls == base_i, req, "no unit call",
          (mul_calls - base_m) + (inv_calls - base_i), 0);
   endtask

   task automatic t_p_inf;
      run_op(7'h11, 7'h22, 1'b1, 7'h35, 7'h4a, 1'b0, 7'h01);
      chk(g_x == 7'h35 && g_y == 7'h4a && !g_inf && !g_err, "R4", "P=O gives Q",
          {g_x, g_y, g_inf}, {7'h35, 7'h4a, 1'b0});
      no_units("R4");
      run_op(7'h11, 7'h22, 1'b1, 7'h35, 7'h4a, 1'b1, 7'h01);
      chk(g_inf && g_x == 0 && g_y == 0 && !g_err, "R4", "O+O", {g_x, g_y, g_inf}, 15'd1);
      no_units("R4");
   endtask

   task automatic t_q_inf;
      run_op(7'h5c, 7'h03, 1'b0, 7'h21, 7'h7f, 1'b1, 7'h00);
      chk(g_x == 7'h5c && g_y == 7'h03 && !g_inf && !g_err, "R5", "Q=O gives P",
          {g_x, g_y, g_inf}, {7'h5c, 7'h03, 1'b0});
      no_units("R5");
   endtask

   task automatic t_negate;
      run_op(7'h2d, 7'h19, 1'b0, 7'h2d, 7'h2d ^ 7'h19, 1'b0, 7'h01);
      chk(g_inf && g_x == 0 && g_y == 0 && !g_err, "R6", "P+(-P)", {g_x, g_y, g_inf}, 15'd1);
      no_units("R6");
      run_op(7'h00, 7'h33, 1'b0, 7'h00, 7'h33, 1'b0, 7'h00);   // xP = 0: P = -P
      chk(g_inf && !g_err, "R6", "xP=0 self-negation", {g_inf, g_err}, 2'b10);
      no_units("R6");
   endtask

   task automatic t_double;
      run_op(7'h41, 7'h0e, 1'b0, 7'h41, 7'h0e, 1'b0, 7'h01);
      chk(g_err && !g_inf && g_x == 0 && g_y == 0, "R7", "P=Q error",
          {g_x, g_y, g_inf, g_err}, 16'd1);
      no_units("R7");
      t_general(7'h12, 7'h34, 7'h56, 7'h78, 7'h00, 1, 1);
      chk(!g_err, "R7", "error cleared by next op", g_err, 0);
   endtask

   task automatic t_same_x;
      run_op(7'h6a, 7'h10, 1'b0, 7'h6a, 7'h55, 1'b0, 7'h01);
      chk(g_inf && !g_err && g_x == 0 && g_y == 0, "R8", "same x other y",
          {g_x, g_y, g_inf, g_err}, 16'd2);
      no_units("R8");
   endtask

   task automatic t_busy;
      logic [FW-1:0] dx, lam, xr, yr;
      int n = 0, dones = 0;
      mul_lat = 6; inv_lat = 3;
      dx  = 7'h13 ^ 7'h2e;
      lam = gmul(7'h05 ^ 7'h61, ginv(dx));
      xr  = gmul(lam, lam) ^ lam ^ dx ^ 7'h01;
      yr  = gmul(lam, 7'h13 ^ xr) ^ xr ^ 7'h05;
      @(negedge clk);
      base_m = mul_calls;
      p_x = 7'h13; p_y = 7'h05; p_inf = 0; q_x = 7'h2e; q_y = 7'h61; q_inf = 0; a2 = 7'h01;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (6) @(negedge clk);
      p_x = 7'h00; p_inf = 1'b1; q_x = 7'h77; start = 1'b1;   // must be ignored
      @(negedge clk); start = 1'b0;
      while (n < 120) begin
         if (done) begin
            dones++;
            if (dones == 1) begin g_x = r_x; g_y = r_y; end
         end
         @(negedge clk); n++;
      end
      chk(dones == 1, "R9", "one done for busy start", dones, 1);
      chk(g_x == xr && g_y == yr, "R9", "first operands kept", {g_x, g_y}, {xr, yr});
      chk(mul_calls - base_m == 3, "R9", "no extra multiplies", mul_calls - base_m, 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state straight after reset release
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !r_err && !r_inf && r_x == 0 && r_y == 0, "R1", "reset outputs",
          {done, r_err, r_inf, r_x, r_y}, 0);
      chk(!mul_start && !inv_start, "R1", "unit requests idle", {mul_start, inv_start}, 0);
      t_general(7'h12, 7'h34, 7'h56, 7'h78, 7'h01, 1, 1);
      t_general(7'h01, 7'h7f, 7'h7e, 7'h00, 7'h00, 3, 5);
      t_general(7'h40, 7'h40, 7'h41, 7'h2a, 7'h01, 5, 2);
      t_general(7'h00, 7'h09, 7'h33, 7'h09, 7'h01, 2, 7);
      t_p_inf;
      t_q_inf;
      t_negate;
      t_double;
      t_same_x;
      t_busy;
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule